// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Receive Buffer

This block is the receive store for one bulk OUT endpoint of a USB device. Two packet buffers of 64 bytes each take turns: while the processor drains one, the bus side can already fill the other. The bus side gives a start strobe for each OUT transaction, then data bytes with a valid strobe, then an end strobe together with a good/bad verdict from the packet checker. The block answers with a one-cycle ACK or NACK pulse.

The processor sees a single logical FIFO. It has one byte-wide read port, a size value and a read-end strobe. Packets reach it strictly in arrival order. A FULL flag and a level interrupt tell it that at least one complete packet is waiting. Which physical buffer feeds the port is never visible to software.

Top module: `bulk_out_pingpong`

## Requirements
- R1: Each of the two buffers holds one packet of 0 to 64 bytes. `rd_size` (7 bits) shows the byte count of the packet at the read port, and shows 0 when no packet is presented.
- R2: A transaction that starts while a buffer is free, and ends with `rx_good`=1 after at most 64 bytes, is stored. `hs_ack` pulses high for one cycle, starting the cycle after the `rx_eop` cycle.
- R3: When both buffers are empty, a first packet may be followed at once by a second one, and the second is also acknowledged and kept without any processor action.
- R4: A transaction that starts while both buffers hold unread packets gets a one-cycle `hs_nack` pulse in the cycle after `rx_eop`. Its data is discarded, and the stored packets and the flags are left unchanged.
- R5: `full_flag` rises in the cycle after a packet is stored. `irq` is a level that is always equal to `full_flag`.
- R6: `rd_data` shows the byte at the current read position. Each `rd_en` cycle advances by one byte. At or past the stored count, `rd_data` is 0 and `rd_en` does not advance.
- R7: A `rd_done` pulse releases the presented packet. The next packet in arrival order is presented from its first byte, and `full_flag` clears only once both buffers are empty.
- R8: A packet with `rx_good`=0 at end, or with more than 64 data bytes, is dropped. It gives neither ACK nor NACK and changes neither `full_flag` nor the presented packet.
- R9: `rd_done` while no packet is presented has no effect, so a packet that arrives later is presented normally.
- R10: When `rst_n` is low at a clock edge, both buffers are emptied, `full_flag`, `irq`, `hs_ack` and `hs_nack` go to 0, and `rd_size` reads 0.
- R11: When a packet ends in the same cycle as `rd_done`, the release and the store both take effect. The new packet is presented next and `full_flag` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_token | input | 1 | One-cycle strobe that starts an OUT transaction |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe, in a cycle of its own after the last byte |
| rx_good | input | 1 | Packet verdict, sampled together with rx_eop |
| hs_ack | output | 1 | One-cycle ACK decision |
| hs_nack | output | 1 | One-cycle NACK decision |
| rd_en | input | 1 | Advance the read position by one byte |
| rd_data | output | 8 | Byte at the read position, 0 past the end |
| rd_size | output | 7 | Byte count of the presented packet |
| rd_done | input | 1 | Read-end strobe, releases the presented packet |
| full_flag | output | 1 | At least one stored packet is unread |
| irq | output | 1 | Interrupt request, level, equal to full_flag |

## Verification
The dangerous overlap is a packet ending in the same cycle as the processor's read-end strobe. The bench stores one packet, streams a second one, and drives `rd_done` in the very cycle of the second packet's `rx_eop`. It then expects an ACK, a FULL flag that never drops, and the second packet's size and first byte at the read port. A NACK transaction whose end coincides with a read-end is also judged, to confirm that the decision made at the start strobe holds.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NACK = 2'd2
    } hs_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_token,
    input  logic          rx_valid,
    input  logic          rx_eop,
    input  logic          rx_good,
    input  logic          rd_en,
    input  logic          rd_done,
    output logic [NB-1:0] wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_sel,
    output logic [AW-1:0] rd_addr,
    output logic          rd_avail,
    output logic [CW-1:0] rd_size,
    output logic          hs_ack,
    output logic          hs_nack,
    output logic          full_flag
);
    typedef struct packed {
        logic                   rx_act;
        logic                   rx_drop;
        logic                   rx_over;
        logic [CW-1:0]          rx_cnt;
        logic                   wr_sel;
        logic                   rd_sel;
        logic [CW-1:0]          rd_ptr;
        logic [NB-1:0]          vld;
        logic [NB-1:0][CW-1:0]  cnt;
        hs_e                    hs;
        logic                   full;
    } st_t;

    st_t st_d, st_q;

    logic rx_beat;
    logic rd_present;

    assign rx_beat    = st_q.rx_act && !rx_token && !rx_eop && rx_valid;
    assign rd_present = st_q.vld[st_q.rd_sel];

    always_comb begin
        st_d    = st_q;
        st_d.hs = HS_NONE;

        // processor side: byte advance, then release
        if (rd_en && rd_present && (st_q.rd_ptr < st_q.cnt[st_q.rd_sel])) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        if (rd_done && rd_present) begin
            st_d.vld[st_q.rd_sel] = 1'b0;
            st_d.rd_sel           = ~st_q.rd_sel;
            st_d.rd_ptr           = '0;
        end

        // bus side
        if (rx_token) begin
            st_d.rx_act  = 1'b1;
            st_d.rx_drop = st_q.vld[st_q.wr_sel];
            st_d.rx_over = 1'b0;
            st_d.rx_cnt  = '0;
        end else if (st_q.rx_act && rx_eop) begin
            st_d.rx_act = 1'b0;
            if (st_q.rx_drop) begin
                st_d.hs = HS_NACK;
            end else if (rx_good && !st_q.rx_over) begin
                st_d.vld[st_q.wr_sel] = 1'b1;
                st_d.cnt[st_q.wr_sel] = st_q.rx_cnt;
                st_d.wr_sel           = ~st_q.wr_sel;
                st_d.hs               = HS_ACK;
            end
        end else if (rx_beat) begin
            if (st_q.rx_cnt == CW'(DEPTH)) st_d.rx_over = 1'b1;
            else                           st_d.rx_cnt  = st_q.rx_cnt + 1'b1;
        end

        st_d.full = |st_d.vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_wen
            assign wr_en[b] = rx_beat && !st_q.rx_drop && (st_q.wr_sel == 1'(b))
                              && (st_q.rx_cnt < CW'(DEPTH));
        end
    endgenerate

    assign wr_addr   = st_q.rx_cnt[AW-1:0];
    assign rd_sel    = st_q.rd_sel;
    assign rd_addr   = st_q.rd_ptr[AW-1:0];
    assign rd_avail  = rd_present && (st_q.rd_ptr < st_q.cnt[st_q.rd_sel]);
    assign rd_size   = rd_present ? st_q.cnt[st_q.rd_sel] : '0;
    assign hs_ack    = (st_q.hs == HS_ACK);
    assign hs_nack   = (st_q.hs == HS_NACK);
    assign full_flag = st_q.full;

    AST_NACK_WHEN_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_token && (&st_q.vld) |=> st_q.rx_drop); // R4
    AST_ACK_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |-> full_flag); // R5
    AST_FULL_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_flag) && $past(rst_n) |-> $past(rd_done)); // R7
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_ptr <= rd_size); // R6
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !rd_present |=> $stable(st_q.rd_sel)); // R9
    AST_BAD_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_act && rx_eop && !rx_token && !rx_good |=> !hs_ack); // R8
    AST_HS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> !hs_ack); // R2
endmodule

// File: rtl/bulk_out_pingpong.sv
module bulk_out_pingpong #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_token,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_eop,
    input  logic          rx_good,
    output logic          hs_ack,
    output logic          hs_nack,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] rd_size,
    input  logic          rd_done,
    output logic          full_flag,
    output logic          irq
);
    logic [NB-1:0] wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_sel;
    logic [AW-1:0] rd_addr;
    logic          rd_avail;
    logic [DW-1:0] bank_rd [NB];

    pp_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_token  (rx_token),
        .rx_valid  (rx_valid),
        .rx_eop    (rx_eop),
        .rx_good   (rx_good),
        .rd_en     (rd_en),
        .rd_done   (rd_done),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_sel    (rd_sel),
        .rd_addr   (rd_addr),
        .rd_avail  (rd_avail),
        .rd_size   (rd_size),
        .hs_ack    (hs_ack),
        .hs_nack   (hs_nack),
        .full_flag (full_flag)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            pp_bank #(.DEPTH(DEPTH), .DW(DW)) bank_i (
                .clk     (clk),
                .wr_en   (wr_en[b]),
                .wr_addr (wr_addr),
                .wr_data (rx_data),
                .rd_addr (rd_addr),
                .rd_data (bank_rd[b])
            );
        end
    endgenerate

    assign rd_data = rd_avail ? bank_rd[rd_sel] : '0;
    assign irq     = full_flag;

    always_comb begin
        AST_IRQ_IS_FULL: assert (!rst_n || irq == full_flag); // R5
    end
endmodule

// File: tb/bulk_out_pingpong_tb.sv
module bulk_out_pingpong_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_token, rx_valid, rx_eop, rx_good;
    logic [7:0] rx_data;
    logic       hs_ack, hs_nack;
    logic       rd_en, rd_done;
    logic [7:0] rd_data;
    logic [6:0] rd_size;
    logic       full_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bulk_out_pingpong dut_i (
        .clk(clk), .rst_n(rst_n), .rx_token(rx_token), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_good(rx_good),
        .hs_ack(hs_ack), .hs_nack(hs_nack), .rd_en(rd_en), .rd_data(rd_data),
        .rd_size(rd_size), .rd_done(rd_done), .full_flag(full_flag), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one transaction; returns the handshake seen after rx_eop.
    task automatic send_pkt(int len, int base, bit good, bit done_at_eop,
                            output bit ack, output bit nack);
        @(negedge clk) rx_token = 1'b1;
        @(negedge clk) rx_token = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(base + i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_eop   = 1'b1;
        rx_good  = good;
        rd_done  = done_at_eop;
        @(negedge clk);
        rx_eop  = 1'b0;
        rx_good = 1'b0;
        rd_done = 1'b0;
        ack  = hs_ack;
        nack = hs_nack;
    endtask

    task automatic pulse_rd_en();
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic pulse_done();
        rd_done = 1'b1;
        @(negedge clk) rd_done = 1'b0;
    endtask

    task automatic read_pkt(string req, int len, int base);
        check({req, " size"}, rd_size, len);
        for (int i = 0; i < len; i++) begin
            check({req, " data"}, rd_data, (base + i) & 8'hff);
            pulse_rd_en();
        end
    endtask

    task automatic t_reset();
        check("R10 full", full_flag, 0);
        check("R10 irq", irq, 0);
        check("R10 size", rd_size, 0);
        check("R10 ack", hs_ack, 0);
        check("R10 nack", hs_nack, 0);
    endtask

    task automatic t_single();
        bit a, n;
        send_pkt(10, 8'h20, 1'b1, 1'b0, a, n);
        check("R2 ack", a, 1);
        check("R2 no nack", n, 0);
        check("R5 full", full_flag, 1);
        check("R5 irq", irq, 1);
        @(negedge clk);
        check("R2 ack one cycle", hs_ack, 0);
        read_pkt("R6", 10, 8'h20);
        check("R6 past end data", rd_data, 0);
        pulse_rd_en();
        check("R6 no advance data", rd_data, 0);
        check("R6 size kept", rd_size, 10);
        pulse_done();
        check("R7 full clear", full_flag, 0);
        check("R7 size after release", rd_size, 0);
    endtask

    task automatic t_pingpong_nack();
        bit a, n;
        send_pkt(3, 8'h40, 1'b1, 1'b0, a, n);
        check("R3 first ack", a, 1);
        send_pkt(64, 8'h80, 1'b1, 1'b0, a, n);
        check("R3 second ack", a, 1);
        check("R1 size of oldest", rd_size, 3);
        send_pkt(5, 8'hC0, 1'b1, 1'b0, a, n);
        check("R4 nack", n, 1);
        check("R4 no ack", a, 0);
        check("R4 full kept", full_flag, 1);
        read_pkt("R7 first", 3, 8'h40);
        pulse_done();
        check("R7 full held", full_flag, 1);
        read_pkt("R1 max packet", 64, 8'h80);
        pulse_done();
        check("R7 full cleared", full_flag, 0);
    endtask

    task automatic t_drops();
        bit a, n;
        send_pkt(4, 8'h11, 1'b0, 1'b0, a, n);
        check("R8 bad no ack", a, 0);
        check("R8 bad no nack", n, 0);
        check("R8 bad full", full_flag, 0);
        send_pkt(65, 8'h00, 1'b1, 1'b0, a, n);
        check("R8 long no ack", a, 0);
        check("R8 long no nack", n, 0);
        check("R8 long full", full_flag, 0);
        check("R8 long size", rd_size, 0);
    endtask

    task automatic t_idle_done();
        bit a, n;
        pulse_done();
        pulse_done();
        check("R9 full", full_flag, 0);
        send_pkt(0, 0, 1'b1, 1'b0, a, n);
        check("R1 zero length ack", a, 1);
        check("R1 zero length size", rd_size, 0);
        check("R1 zero length data", rd_data, 0);
        pulse_done();
        send_pkt(2, 8'h55, 1'b1, 1'b0, a, n);
        check("R9 later packet ack", a, 1);
        read_pkt("R9 later packet", 2, 8'h55);
        pulse_done();
        check("R9 full after", full_flag, 0);
    endtask

    task automatic t_collide();
        bit a, n;
        send_pkt(5, 8'h30, 1'b1, 1'b0, a, n);
        send_pkt(7, 8'h70, 1'b1, 1'b1, a, n);
        check("R11 ack", a, 1);
        check("R11 full stays", full_flag, 1);
        check("R11 size", rd_size, 7);
        check("R11 data", rd_data, 8'h70);
        // fill second buffer, then a NACK transaction ending on a release
        send_pkt(2, 8'hA0, 1'b1, 1'b0, a, n);
        check("R11 refill ack", a, 1);
        send_pkt(3, 8'hE0, 1'b1, 1'b1, a, n);
        check("R4 nack despite release", n, 1);
        read_pkt("R11 order", 2, 8'hA0);
        pulse_done();
        check("R11 full clear", full_flag, 0);
    endtask

    initial begin
        rst_n = 1'b0; rx_token = 0; rx_valid = 0; rx_data = 0;
        rx_eop = 0; rx_good = 0; rd_en = 0; rd_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_pingpong_nack();
        t_drops();
        t_idle_done();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule